// File: doc/BRIEF.md
# Per-Destination EOI Pending Tracker

This block watches one edge-triggered interrupt line and decides whether a fresh assertion of that line may go out, or has to be reported as coalesced because an earlier delivery is still unacknowledged. When a delivery completes, the delivery fabric returns the set of destinations that accepted it and how many there were. The tracker stores that set as a bitmap and the number as a pending count. Each destination later sends an end-of-interrupt (EOI), which clears its bit and lowers the count. Whenever the count is non-zero, a new assertion is refused as coalesced.

The bitmap and the count can fall out of step: the fabric may report a count that differs from the mask, or software may restore state. Each destination's bit can therefore be repaired on its own, by comparing it with that destination's live pending-EOI flag, which is presented on `live_pend_i`. A full rebuild is also available. It wipes the state and then walks every destination, one per cycle. A rebuild starts on request, and it also starts by itself whenever an EOI or a restore would take the count below zero. Only destinations flagged in `dest_match_i` (those matching the line's programmed destination) take part in a restore.

The controller has four states. `TS_IDLE` accepts assertions, EOIs, restores and rebuild requests. `TS_WAIT` waits for the delivery result. `TS_WIPE` clears the bitmap and the count. `TS_SCAN` walks the destinations. The transitions are:
- IDLE to WIPE on a rebuild request or an underflow.
- IDLE to WAIT when an assertion is issued.
- WAIT to IDLE when the delivery completes.
- WIPE to SCAN after one cycle.
- SCAN to IDLE after the last destination.

Top module: `eoi_pend_tracker`

## Requirements
- R1: Asynchronous reset (`rst_n` low) clears the pending count, the whole bitmap and `busy_o`, and leaves the controller in TS_IDLE.
- R2: In TS_IDLE, with the count at 0 and no rebuild request, no EOI and no restore that cycle, `line_req_i` raises `issue_o` in the same cycle with `coalesced_o` low. The controller then enters TS_WAIT.
- R3: `line_req_i` raises `coalesced_o`, and leaves `issue_o` low, whenever the count is non-zero or the controller is not in TS_IDLE.
- R4: `dlv_done_i` in TS_WAIT loads the bitmap with `dlv_mask_i` on the next edge and returns the controller to TS_IDLE. The count is loaded with `dlv_cnt_i`, or with 0 when `dlv_fail_i` is high; the mask is loaded in both cases.
- R5: In TS_IDLE, an EOI for destination d (with d < NDEST) whose bit is set and whose count is non-zero clears bit d and decrements the count. An EOI for a clear bit, or with d >= NDEST, changes nothing.
- R6: EOIs act only in TS_IDLE. An EOI arriving in the same cycle as a delivery completion, or at any time in TS_WAIT, is dropped, and the delivery result is loaded unchanged.
- R7: An EOI or a restore that would clear a set bit while the count is 0 starts a rebuild instead. The rebuild ends with bitmap = `live_pend_i & dest_match_i` and the count equal to the number of ones in that value.
- R8: `rebuild_i` in TS_IDLE starts a rebuild. It takes priority over an EOI, a restore and an issue in the same cycle.
- R9: A restore of destination d (`restore_one_i`, TS_IDLE, no EOI that cycle) acts only if `dest_match_i[d]` is set and `live_pend_i[d]` differs from bit d. It then sets the bit and increments the count, or clears the bit and decrements the count. Otherwise nothing changes.
- R10: `busy_o` is high for exactly NDEST+1 consecutive cycles per rebuild: one TS_WIPE cycle and NDEST TS_SCAN cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_req_i | input | 1 | New assertion of the tracked line |
| issue_o | output | 1 | Assertion accepted; hand it to the delivery fabric |
| coalesced_o | output | 1 | Assertion refused as coalesced |
| dlv_done_i | input | 1 | Delivery result valid |
| dlv_fail_i | input | 1 | Delivery failed; the count is loaded as 0 |
| dlv_cnt_i | input | CW | Number of accepting destinations |
| dlv_mask_i | input | NDEST | Accepting destinations |
| eoi_valid_i | input | 1 | EOI report valid |
| eoi_dest_i | input | IW | Destination sending the EOI |
| restore_one_i | input | 1 | Per-destination restore request |
| restore_dest_i | input | IW | Destination to restore |
| rebuild_i | input | 1 | Full rebuild request |
| live_pend_i | input | NDEST | Live pending-EOI flag of each destination |
| dest_match_i | input | NDEST | Destinations matching the line's programmed destination |
| busy_o | output | 1 | Rebuild in progress |
| pend_map_o | output | NDEST | Destinations still owing an EOI |
| pend_cnt_o | output | CW | Pending EOI count |

## Verification
The bench builds the tracker with NDEST = 5. This gives a 3-bit destination index that can also carry the out-of-range values 5 to 7, so EOIs for destinations that do not exist can be checked. It also gives a 3-bit count with headroom above the mask width. With five destinations a rebuild lasts six cycles, so the bench can count the whole busy window. It can also use masks that disagree with the reported count, which creates the underflow that triggers self-repair.

// File: rtl/eoi_trk_pkg.sv
package eoi_trk_pkg;

    // Controller states
    typedef enum logic [1:0] {
        TS_IDLE = 2'd0,
        TS_WAIT = 2'd1,
        TS_WIPE = 2'd2,
        TS_SCAN = 2'd3
    } trk_state_e;

    // Operation applied to the bitmap and counter this cycle
    typedef enum logic [2:0] {
        MO_HOLD = 3'd0,
        MO_LOAD = 3'd1,
        MO_WIPE = 3'd2,
        MO_SET  = 3'd3,
        MO_CLR  = 3'd4
    } map_op_e;

endpackage

// File: rtl/eoi_trk_decide.sv
module eoi_trk_decide
    import eoi_trk_pkg::*;
#(
    parameter int unsigned NDEST = 8,
    parameter int unsigned CW    = 4,
    parameter int unsigned IW    = 3
) (
    input  trk_state_e       st,
    input  logic [IW-1:0]    scan_idx,
    input  logic             line_req,
    input  logic             rebuild,
    input  logic             eoi_valid,
    input  logic [IW-1:0]    eoi_dest,
    input  logic             restore_one,
    input  logic [IW-1:0]    restore_dest,
    input  logic             dlv_done,
    input  logic [NDEST-1:0] live,
    input  logic [NDEST-1:0] match,
    input  logic [NDEST-1:0] map,
    input  logic [CW-1:0]    cnt,
    output map_op_e          op,
    output logic [IW-1:0]    op_idx,
    output logic             go_wipe,
    output logic             issue
);

    localparam logic [IW:0] NLIM = (IW+1)'(NDEST);

    logic eoi_in_rng;
    logic eoi_hit;
    logic rs_in_rng;
    logic rs_differs;
    logic cnt_zero;

    always_comb begin
        eoi_in_rng = ({1'b0, eoi_dest} < NLIM);
        eoi_hit    = eoi_valid && eoi_in_rng && map[eoi_dest];
        rs_in_rng  = ({1'b0, restore_dest} < NLIM);
        rs_differs = restore_one && rs_in_rng && match[restore_dest]
                     && (live[restore_dest] != map[restore_dest]);
        cnt_zero   = (cnt == '0);
    end

    always_comb begin
        op      = MO_HOLD;
        op_idx  = '0;
        go_wipe = 1'b0;
        issue   = 1'b0;
        unique case (st)
            TS_IDLE: begin
                if (rebuild) begin
                    go_wipe = 1'b1;
                end else if (eoi_valid) begin
                    // an EOI blocks any restore in the same cycle
                    if (eoi_hit) begin
                        if (cnt_zero) begin
                            go_wipe = 1'b1;
                        end else begin
                            op     = MO_CLR;
                            op_idx = eoi_dest;
                        end
                    end
                end else if (rs_differs) begin
                    if (live[restore_dest]) begin
                        op     = MO_SET;
                        op_idx = restore_dest;
                    end else if (cnt_zero) begin
                        go_wipe = 1'b1;
                    end else begin
                        op     = MO_CLR;
                        op_idx = restore_dest;
                    end
                end
                if (!go_wipe && line_req && cnt_zero && !eoi_valid && !restore_one) begin
                    issue = 1'b1;
                end
            end
            TS_WAIT: begin
                if (dlv_done) begin
                    op = MO_LOAD;
                end
            end
            TS_WIPE: begin
                op = MO_WIPE;
            end
            TS_SCAN: begin
                // the bitmap is all zero after the wipe, so only sets occur
                if (match[scan_idx] && live[scan_idx] && !map[scan_idx]) begin
                    op     = MO_SET;
                    op_idx = scan_idx;
                end
            end
            default: begin
                op = MO_HOLD;
            end
        endcase
    end

endmodule

// File: rtl/eoi_trk_fsm.sv
module eoi_trk_fsm
    import eoi_trk_pkg::*;
#(
    parameter int unsigned NDEST = 8,
    parameter int unsigned IW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_wipe,
    input  logic          issue,
    input  logic          dlv_done,
    output trk_state_e    st,
    output logic [IW-1:0] scan_idx,
    output logic          busy
);

    localparam logic [IW-1:0] LAST_IDX = IW'(NDEST - 1);

    trk_state_e    st_q, st_d;
    logic [IW-1:0] idx_q, idx_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TS_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        unique case (st_q)
            TS_IDLE: begin
                if (go_wipe) begin
                    st_d = TS_WIPE;
                end else if (issue) begin
                    st_d = TS_WAIT;
                end
            end
            TS_WAIT: begin
                if (dlv_done) begin
                    st_d = TS_IDLE;
                end
            end
            TS_WIPE: begin
                st_d  = TS_SCAN;
                idx_d = '0;
            end
            TS_SCAN: begin
                if (idx_q == LAST_IDX) begin
                    st_d  = TS_IDLE;
                    idx_d = '0;
                end else begin
                    idx_d = idx_q + IW'(1);
                end
            end
            default: begin
                st_d = TS_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        st       = st_q;
        scan_idx = idx_q;
        unique case (st_q)
            TS_WIPE, TS_SCAN: busy = 1'b1;
            default:          busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/eoi_trk_store.sv
module eoi_trk_store
    import eoi_trk_pkg::*;
#(
    parameter int unsigned NDEST = 8,
    parameter int unsigned CW    = 4,
    parameter int unsigned IW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  map_op_e          op,
    input  logic [IW-1:0]    op_idx,
    input  logic [NDEST-1:0] dlv_mask,
    input  logic [CW-1:0]    dlv_cnt,
    input  logic             dlv_fail,
    output logic [NDEST-1:0] map,
    output logic [CW-1:0]    cnt
);

    logic [NDEST-1:0] map_q;
    logic [CW-1:0]    cnt_q;

    for (genvar b = 0; b < NDEST; b++) begin : g_bit
        logic sel;
        assign sel = (op_idx == IW'(b));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                map_q[b] <= 1'b0;
            end else begin
                unique case (op)
                    MO_LOAD: map_q[b] <= dlv_mask[b];
                    MO_WIPE: map_q[b] <= 1'b0;
                    MO_SET:  if (sel) map_q[b] <= 1'b1;
                    MO_CLR:  if (sel) map_q[b] <= 1'b0;
                    default: map_q[b] <= map_q[b];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (op)
                MO_LOAD: cnt_q <= dlv_fail ? '0 : dlv_cnt;
                MO_WIPE: cnt_q <= '0;
                MO_SET:  cnt_q <= cnt_q + CW'(1);
                MO_CLR:  cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign map = map_q;
    assign cnt = cnt_q;

endmodule

// File: rtl/eoi_pend_tracker.sv
module eoi_pend_tracker
    import eoi_trk_pkg::*;
#(
    parameter  int unsigned NDEST = 8,
    localparam int unsigned CW    = $clog2(NDEST + 1),
    localparam int unsigned IW    = (NDEST > 1) ? $clog2(NDEST) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_req_i,
    output logic             issue_o,
    output logic             coalesced_o,
    input  logic             dlv_done_i,
    input  logic             dlv_fail_i,
    input  logic [CW-1:0]    dlv_cnt_i,
    input  logic [NDEST-1:0] dlv_mask_i,
    input  logic             eoi_valid_i,
    input  logic [IW-1:0]    eoi_dest_i,
    input  logic             restore_one_i,
    input  logic [IW-1:0]    restore_dest_i,
    input  logic             rebuild_i,
    input  logic [NDEST-1:0] live_pend_i,
    input  logic [NDEST-1:0] dest_match_i,
    output logic             busy_o,
    output logic [NDEST-1:0] pend_map_o,
    output logic [CW-1:0]    pend_cnt_o
);

    trk_state_e       st_q;
    logic [IW-1:0]    scan_idx;
    map_op_e          op;
    logic [IW-1:0]    op_idx;
    logic             go_wipe;
    logic             issue;
    logic [NDEST-1:0] map;
    logic [CW-1:0]    cnt;

    eoi_trk_decide #(.NDEST(NDEST), .CW(CW), .IW(IW)) u_decide (
        .st          (st_q),
        .scan_idx    (scan_idx),
        .line_req    (line_req_i),
        .rebuild     (rebuild_i),
        .eoi_valid   (eoi_valid_i),
        .eoi_dest    (eoi_dest_i),
        .restore_one (restore_one_i),
        .restore_dest(restore_dest_i),
        .dlv_done    (dlv_done_i),
        .live        (live_pend_i),
        .match       (dest_match_i),
        .map         (map),
        .cnt         (cnt),
        .op          (op),
        .op_idx      (op_idx),
        .go_wipe     (go_wipe),
        .issue       (issue)
    );

    eoi_trk_fsm #(.NDEST(NDEST), .IW(IW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_wipe (go_wipe),
        .issue   (issue),
        .dlv_done(dlv_done_i),
        .st      (st_q),
        .scan_idx(scan_idx),
        .busy    (busy_o)
    );

    eoi_trk_store #(.NDEST(NDEST), .CW(CW), .IW(IW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .op_idx  (op_idx),
        .dlv_mask(dlv_mask_i),
        .dlv_cnt (dlv_cnt_i),
        .dlv_fail(dlv_fail_i),
        .map     (map),
        .cnt     (cnt)
    );

    assign issue_o     = issue;
    assign coalesced_o = line_req_i && !issue;
    assign pend_map_o  = map;
    assign pend_cnt_o  = cnt;

endmodule

// File: rtl/eoi_trk_chk.sv
module eoi_trk_chk
    import eoi_trk_pkg::*;
#(
    parameter int unsigned NDEST = 8,
    parameter int unsigned CW    = 4,
    parameter int unsigned IW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input trk_state_e       st,
    input logic             line_req_i,
    input logic             issue_o,
    input logic             coalesced_o,
    input logic             busy_o,
    input logic             dlv_done_i,
    input logic [NDEST-1:0] dlv_mask_i,
    input logic             eoi_valid_i,
    input logic [IW-1:0]    eoi_dest_i,
    input logic             restore_one_i,
    input logic             rebuild_i,
    input logic [NDEST-1:0] pend_map_o,
    input logic [CW-1:0]    pend_cnt_o
);

    localparam logic [IW:0] NLIM = (IW+1)'(NDEST);
    localparam int unsigned RW   = $clog2(NDEST + 3);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (busy_o) run_q <= run_q + RW'(1);
        else             run_q <= '0;
    end

    // R3
    coalesce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_req_i && (pend_cnt_o != '0 || st != TS_IDLE)) |-> (coalesced_o && !issue_o));

    // R2
    issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TS_IDLE && line_req_i && pend_cnt_o == '0 && !rebuild_i
         && !eoi_valid_i && !restore_one_i) |-> (issue_o && !coalesced_o));

    // R4
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TS_WAIT && dlv_done_i) |=> (pend_map_o == $past(dlv_mask_i) && st == TS_IDLE));

    // R5
    eoi_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TS_IDLE && !rebuild_i && eoi_valid_i && ({1'b0, eoi_dest_i} < NLIM)
         && pend_map_o[eoi_dest_i] && pend_cnt_o != '0)
        |=> (pend_cnt_o == $past(pend_cnt_o) - CW'(1) && !pend_map_o[$past(eoi_dest_i)]));

    // R8
    rebuild_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TS_IDLE && rebuild_i) |=> (st == TS_WIPE && busy_o));

    // R7
    wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TS_WIPE) |=> (pend_cnt_o == '0 && pend_map_o == '0 && st == TS_SCAN));

    // R10
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && run_q != '0) |-> (run_q == RW'(NDEST + 1)));

endmodule

bind eoi_pend_tracker eoi_trk_chk #(.NDEST(NDEST), .CW(CW), .IW(IW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st           (st_q),
    .line_req_i   (line_req_i),
    .issue_o      (issue_o),
    .coalesced_o  (coalesced_o),
    .busy_o       (busy_o),
    .dlv_done_i   (dlv_done_i),
    .dlv_mask_i   (dlv_mask_i),
    .eoi_valid_i  (eoi_valid_i),
    .eoi_dest_i   (eoi_dest_i),
    .restore_one_i(restore_one_i),
    .rebuild_i    (rebuild_i),
    .pend_map_o   (pend_map_o),
    .pend_cnt_o   (pend_cnt_o)
);

// File: tb/test_eoi_pend_tracker.sv
`timescale 1ns/1ps
module test_eoi_pend_tracker;

    localparam int unsigned NDEST  = 5;
    localparam int unsigned CW     = 3;
    localparam int unsigned IW     = 3;
    localparam real         CLK_NS = 8.0;

    localparam logic [1:0] K_FIRE = 2'd0;
    localparam logic [1:0] K_EOI  = 2'd1;
    localparam logic [1:0] K_RST  = 2'd2;

    typedef struct packed {
        logic [1:0] kind;
        logic [2:0] dest;
        logic [4:0] mask;
        logic [2:0] cnt;
        logic       fail;
        logic [4:0] live;
        logic [4:0] match;
        logic       exp_coal;
        logic [2:0] exp_cnt;
        logic [4:0] exp_map;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{K_FIRE, 3'd0, 5'b00110, 3'd2, 1'b0, 5'b00000, 5'b11111, 1'b0, 3'd2, 5'b00110, 4'd4},  // R4 first delivery
        '{K_FIRE, 3'd0, 5'b00000, 3'd0, 1'b0, 5'b00000, 5'b11111, 1'b1, 3'd2, 5'b00110, 4'd3},  // R3 coalesced
        '{K_EOI,  3'd1, 5'b00000, 3'd0, 1'b0, 5'b00000, 5'b11111, 1'b0, 3'd1, 5'b00100, 4'd5},  // R5 hit
        '{K_EOI,  3'd1, 5'b00000, 3'd0, 1'b0, 5'b00000, 5'b11111, 1'b0, 3'd1, 5'b00100, 4'd5},  // R5 bit clear
        '{K_EOI,  3'd6, 5'b00000, 3'd0, 1'b0, 5'b00000, 5'b11111, 1'b0, 3'd1, 5'b00100, 4'd5},  // R5 out of range
        '{K_EOI,  3'd2, 5'b00000, 3'd0, 1'b0, 5'b00000, 5'b11111, 1'b0, 3'd0, 5'b00000, 4'd5},  // R5 last one
        '{K_FIRE, 3'd0, 5'b10001, 3'd2, 1'b1, 5'b00000, 5'b11111, 1'b0, 3'd0, 5'b10001, 4'd4},  // R4 failed delivery
        '{K_RST,  3'd3, 5'b00000, 3'd0, 1'b0, 5'b01000, 5'b11111, 1'b0, 3'd1, 5'b11001, 4'd9},  // R9 set
        '{K_RST,  3'd3, 5'b00000, 3'd0, 1'b0, 5'b01000, 5'b11111, 1'b0, 3'd1, 5'b11001, 4'd9},  // R9 equal
        '{K_RST,  3'd2, 5'b00000, 3'd0, 1'b0, 5'b00100, 5'b11011, 1'b0, 3'd1, 5'b11001, 4'd9},  // R9 no match
        '{K_RST,  3'd3, 5'b00000, 3'd0, 1'b0, 5'b00000, 5'b11111, 1'b0, 3'd0, 5'b10001, 4'd9},  // R9 clear
        '{K_FIRE, 3'd0, 5'b00011, 3'd2, 1'b0, 5'b00000, 5'b11111, 1'b0, 3'd2, 5'b00011, 4'd2}   // R2 issue
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             line_req_i = 1'b0;
    logic             issue_o, coalesced_o, busy_o;
    logic             dlv_done_i = 1'b0;
    logic             dlv_fail_i = 1'b0;
    logic [CW-1:0]    dlv_cnt_i = '0;
    logic [NDEST-1:0] dlv_mask_i = '0;
    logic             eoi_valid_i = 1'b0;
    logic [IW-1:0]    eoi_dest_i = '0;
    logic             restore_one_i = 1'b0;
    logic [IW-1:0]    restore_dest_i = '0;
    logic             rebuild_i = 1'b0;
    logic [NDEST-1:0] live_pend_i = '0;
    logic [NDEST-1:0] dest_match_i = '0;
    logic [NDEST-1:0] pend_map_o;
    logic [CW-1:0]    pend_cnt_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_NS / 2.0) clk = ~clk;

    eoi_pend_tracker #(.NDEST(NDEST)) i_eoi_pend_tracker (
        .clk(clk), .rst_n(rst_n), .line_req_i(line_req_i), .issue_o(issue_o),
        .coalesced_o(coalesced_o), .dlv_done_i(dlv_done_i), .dlv_fail_i(dlv_fail_i),
        .dlv_cnt_i(dlv_cnt_i), .dlv_mask_i(dlv_mask_i), .eoi_valid_i(eoi_valid_i),
        .eoi_dest_i(eoi_dest_i), .restore_one_i(restore_one_i),
        .restore_dest_i(restore_dest_i), .rebuild_i(rebuild_i),
        .live_pend_i(live_pend_i), .dest_match_i(dest_match_i), .busy_o(busy_o),
        .pend_map_o(pend_map_o), .pend_cnt_o(pend_cnt_o)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fire(input logic [4:0] mask, input logic [2:0] cnt, input logic fail);
        line_req_i = 1'b1;
        cyc();
        line_req_i = 1'b0;
        dlv_done_i = 1'b1; dlv_mask_i = mask; dlv_cnt_i = cnt; dlv_fail_i = fail;
        cyc();
        dlv_done_i = 1'b0; dlv_fail_i = 1'b0;
    endtask

    task automatic eoi(input logic [2:0] d);
        eoi_valid_i = 1'b1; eoi_dest_i = d;
        cyc();
        eoi_valid_i = 1'b0;
    endtask

    task automatic wait_rebuild(input string rq, input logic [4:0] exp_map, input logic [2:0] exp_cnt);
        int n;
        n = 0;
        while (busy_o && n < 50) begin
            n++;
            cyc();
        end
        chk(rq, "busy length", 32'(n), 32'(NDEST + 1));
        chk(rq, "rebuilt map", 32'(pend_map_o), 32'(exp_map));
        chk(rq, "rebuilt count", 32'(pend_cnt_o), 32'(exp_cnt));
    endtask

    initial begin
        #(CLK_NS * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "count at reset", 32'(pend_cnt_o), 32'd0);
        chk("R1", "map at reset", 32'(pend_map_o), 32'd0);
        chk("R1", "busy at reset", 32'(busy_o), 32'd0);
        rst_n = 1'b1;
        cyc();

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string rq;
            v = VT[i];
            rq = $sformatf("R%0d vec%0d", v.req, i);
            live_pend_i  = v.live;
            dest_match_i = v.match;
            unique case (v.kind)
                K_FIRE: begin
                    line_req_i = 1'b1;
                    #1;
                    chk(rq, "coalesced", 32'(coalesced_o), 32'(v.exp_coal));
                    chk(rq, "issue", 32'(issue_o), 32'(!v.exp_coal));
                    cyc();
                    line_req_i = 1'b0;
                    if (!v.exp_coal) begin
                        dlv_done_i = 1'b1; dlv_mask_i = v.mask;
                        dlv_cnt_i = v.cnt; dlv_fail_i = v.fail;
                        cyc();
                        dlv_done_i = 1'b0; dlv_fail_i = 1'b0;
                    end
                end
                K_EOI: eoi(v.dest);
                default: begin
                    restore_one_i = 1'b1; restore_dest_i = v.dest;
                    cyc();
                    restore_one_i = 1'b0;
                end
            endcase
            chk(rq, "count", 32'(pend_cnt_o), 32'(v.exp_cnt));
            chk(rq, "map", 32'(pend_map_o), 32'(v.exp_map));
        end

        // R7 underflow from a mask that disagrees with the count
        eoi(3'd0);
        eoi(3'd1);
        fire(5'b11100, 3'd1, 1'b0);
        eoi(3'd2);
        chk("R5", "count before underflow", 32'(pend_cnt_o), 32'd0);
        live_pend_i = 5'b10110; dest_match_i = 5'b01111;
        eoi(3'd3);
        chk("R7", "busy after underflow", 32'(busy_o), 32'd1);
        line_req_i = 1'b1;
        #1;
        chk("R3", "coalesced while busy", 32'(coalesced_o), 32'd1);
        line_req_i = 1'b0;
        wait_rebuild("R7 R10", 5'b00110, 3'd2);

        // R8 rebuild request beats a same-cycle EOI
        live_pend_i = 5'b00001; dest_match_i = 5'b11111;
        rebuild_i = 1'b1; eoi_valid_i = 1'b1; eoi_dest_i = 3'd1;
        cyc();
        rebuild_i = 1'b0; eoi_valid_i = 1'b0;
        chk("R8", "busy after request", 32'(busy_o), 32'd1);
        wait_rebuild("R8 R10", 5'b00001, 3'd1);

        // R6 delivery wins over an EOI in the same cycle
        eoi(3'd0);
        line_req_i = 1'b1;
        cyc();
        #1;
        chk("R3", "coalesced in wait", 32'(coalesced_o), 32'd1);
        chk("R3", "no issue in wait", 32'(issue_o), 32'd0);
        line_req_i = 1'b0;
        eoi_valid_i = 1'b1; eoi_dest_i = 3'd2;
        dlv_done_i = 1'b1; dlv_mask_i = 5'b00100; dlv_cnt_i = 3'd1;
        cyc();
        eoi_valid_i = 1'b0; dlv_done_i = 1'b0;
        chk("R6", "map after clash", 32'(pend_map_o), 32'h04);
        chk("R6", "count after clash", 32'(pend_cnt_o), 32'd1);

        // R1 reset while state is held
        rst_n = 1'b0;
        #1;
        chk("R1", "count cleared", 32'(pend_cnt_o), 32'd0);
        chk("R1", "map cleared", 32'(pend_map_o), 32'd0);
        cyc();
        rst_n = 1'b1;
        cyc();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule